// File: doc/BRIEF.md
# Noise-Averaging SAR Transition Finder

This controller finds the input level at which an analog-to-digital converter under test moves from one output code to the next. It drives a wide code word to an external precision DAC whose output feeds the converter under test. It reads back the converter's output code and compares it with a target code supplied by the host. The search is a successive approximation, most significant bit first. The first trial is half scale. Each later step decides whether to keep the current trial bit and then tries the next lower weight.

Near a transition the converter's output flickers with noise, so a single compare would be unreliable. Each bit decision is therefore a majority vote taken over a window of 2^M clock cycles. A comparator-high counter is tested against half the window. M is chosen at start, which lets the host trade test time against noise rejection.

After every DAC update a fixed number of settle cycles passes before counting begins, so converter latency stays out of the vote. The host repeats one full search per transition while sweeping the target code. The final DAC word is the 50% point of that transition.

Top module: `sarTransitionFinder`

## Requirements
- R1: After reset, `done` is 0, `result` is 0 and `dacCode` is 0.
- R2: A `start` sampled while idle makes `dacCode` equal to half scale (only the top bit set) on the following cycle.
- R3: One search makes exactly DAC_W bit decisions, top bit first. From the edge that samples `start` to the edge that raises `done` takes DAC_W*(SETTLE_CYC + 2^M + 1) cycles. Settle cycles are not counted in the vote.
- R4: When a decision says "greater" (ADC code above target), the trial bit is cleared; otherwise it is kept. On a noise-free monotonic converter, the result is the largest DAC word whose ADC code is not above the target.
- R5: A decision is "greater" only when the number of window cycles with ADC code above target is strictly more than 2^(M-1). An exact tie counts as not greater.
- R6: `done` is high for exactly one cycle. In that cycle `result` equals `dacCode`, and `result` holds until the next search ends.
- R7: A `start` seen while a search is running is ignored. The search continues with its original target, and its trial word does not change outside decision cycles.
- R8: M and the target are captured at start and held for the whole search. An M of 0 is treated as 1, and values above 16 (MAX_M) are treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search when idle |
| targetCode | input | ADC_W | Reference code to locate |
| winExp | input | MEXP_W | Vote window exponent M |
| adcCode | input | ADC_W | Output code of the converter under test |
| dacCode | output | DAC_W | Trial word to the precision DAC |
| result | output | DAC_W | Final transition word |
| done | output | 1 | One-cycle end-of-search pulse |

## Verification
The assertions check four things on every cycle: the one-cycle `done` pulse and its agreement with `dacCode`, the half-scale first trial, the trial word staying still outside decision cycles even when `start` arrives mid-search, and the captured M staying inside its clamped range. Other behaviour is visible only through bench scenarios. These include the converged transition word, and the vote outcome under noise patterns whose duty cycles are below, at and above half of the window. They also include the exact search length, which exposes the settle count and window size, and the effect of changing M or the target while a search runs.

// File: rtl/sarFinderPkg.sv
package sarFinderPkg;
  typedef struct packed {
    logic launch;     // begin a new search
    logic voteClr;    // clear the comparator-high counter
    logic voteEn;     // count this cycle into the vote
    logic voteLatch;  // last window cycle: latch the majority
    logic applyBit;   // apply latched decision to the trial word
  } sarStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_VOTE, ST_APPLY} sarState_t;
endpackage

// File: rtl/sarCtrl.sv
module sarCtrl
  import sarFinderPkg::*;
#(
  parameter int MAX_M      = 16,
  parameter int SETTLE_CYC = 4,
  parameter int MEXP_W     = 5,
  parameter int CNT_W      = MAX_M + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MEXP_W-1:0] winExp,
  input  logic              lastBit,
  output sarStrobe_t        strobe,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  halfWin,
  output logic [MEXP_W-1:0] mHeld
);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);

  sarState_t         state;
  logic [SET_W-1:0]  setCnt;
  logic [CNT_W-1:0]  winCnt;
  logic [CNT_W-1:0]  winLast;
  logic [MEXP_W-1:0] mClamp;

  always_comb begin
    if (winExp == '0)                        mClamp = MEXP_W'(1);
    else if (winExp > MEXP_W'(MAX_M))        mClamp = MEXP_W'(MAX_M);
    else                                     mClamp = winExp;
  end

  assign winLast = (CNT_W'(1) << mHeld) - CNT_W'(1);
  assign halfWin = CNT_W'(1) << (mHeld - MEXP_W'(1));
  assign busy    = (state != ST_IDLE);

  always_comb begin
    strobe = '0;
    case (state)
      ST_IDLE:   strobe.launch    = start;
      ST_SETTLE: strobe.voteClr   = (setCnt == SET_W'(SETTLE_CYC - 1));
      ST_VOTE: begin
        strobe.voteEn    = 1'b1;
        strobe.voteLatch = (winCnt == winLast);
      end
      ST_APPLY:  strobe.applyBit  = 1'b1;
      default:   strobe = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      setCnt <= '0;
      winCnt <= '0;
      mHeld  <= MEXP_W'(1);
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          mHeld  <= mClamp;
          setCnt <= '0;
          state  <= ST_SETTLE;
        end
        ST_SETTLE: begin
          setCnt <= setCnt + SET_W'(1);
          if (strobe.voteClr) begin
            winCnt <= '0;
            state  <= ST_VOTE;
          end
        end
        ST_VOTE: begin
          winCnt <= winCnt + CNT_W'(1);
          if (strobe.voteLatch) state <= ST_APPLY;
        end
        ST_APPLY: begin
          setCnt <= '0;
          if (lastBit) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_SETTLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sarPath.sv
module sarPath
  import sarFinderPkg::*;
#(
  parameter int DAC_W = 16,
  parameter int ADC_W = 10,
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sarStrobe_t       strobe,
  input  logic [ADC_W-1:0] adcCode,
  input  logic [ADC_W-1:0] targetCode,
  input  logic [CNT_W-1:0] halfWin,
  output logic [DAC_W-1:0] dacCode,
  output logic [DAC_W-1:0] result,
  output logic             lastBit
);
  localparam logic [DAC_W-1:0] TOP_BIT = {1'b1, {(DAC_W-1){1'b0}}};

  logic [DAC_W-1:0] trial, bitMask, trialKept;
  logic [ADC_W-1:0] targetHeld;
  logic [CNT_W-1:0] hiCnt;
  logic             decGreater;
  logic             isAbove;

  assign isAbove   = (adcCode > targetHeld);
  assign trialKept = decGreater ? (trial & ~bitMask) : trial;
  assign lastBit   = bitMask[0];
  assign dacCode   = trial;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial      <= '0;
      bitMask    <= '0;
      targetHeld <= '0;
      hiCnt      <= '0;
      decGreater <= 1'b0;
      result     <= '0;
    end else begin
      if (strobe.launch) begin
        trial      <= TOP_BIT;
        bitMask    <= TOP_BIT;
        targetHeld <= targetCode;
      end
      if (strobe.voteClr) hiCnt <= '0;
      if (strobe.voteEn)  hiCnt <= hiCnt + CNT_W'(isAbove);
      if (strobe.voteLatch)
        decGreater <= (hiCnt + CNT_W'(isAbove)) > halfWin;
      if (strobe.applyBit) begin
        if (bitMask[0]) begin
          trial  <= trialKept;
          result <= trialKept;
        end else begin
          trial   <= trialKept | (bitMask >> 1);
          bitMask <= bitMask >> 1;
        end
      end
    end
  end
endmodule

// File: rtl/sarTransitionFinder.sv
module sarTransitionFinder
  import sarFinderPkg::*;
#(
  parameter int DAC_W      = 16,
  parameter int ADC_W      = 10,
  parameter int MAX_M      = 16,
  parameter int SETTLE_CYC = 4,
  localparam int MEXP_W    = $clog2(MAX_M + 1),
  localparam int CNT_W     = MAX_M + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADC_W-1:0]  targetCode,
  input  logic [MEXP_W-1:0] winExp,
  input  logic [ADC_W-1:0]  adcCode,
  output logic [DAC_W-1:0]  dacCode,
  output logic [DAC_W-1:0]  result,
  output logic              done
);
  sarStrobe_t        strobe;
  logic              busy, lastBit;
  logic [CNT_W-1:0]  halfWin;
  logic [MEXP_W-1:0] mHeld;

  sarCtrl #(.MAX_M(MAX_M), .SETTLE_CYC(SETTLE_CYC), .MEXP_W(MEXP_W), .CNT_W(CNT_W)) ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .winExp(winExp), .lastBit(lastBit),
    .strobe(strobe), .busy(busy), .done(done), .halfWin(halfWin), .mHeld(mHeld)
  );

  sarPath #(.DAC_W(DAC_W), .ADC_W(ADC_W), .CNT_W(CNT_W)) path (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .adcCode(adcCode),
    .targetCode(targetCode), .halfWin(halfWin), .dacCode(dacCode),
    .result(result), .lastBit(lastBit)
  );
endmodule

// File: rtl/sarFinderChecker.sv
module sarFinderChecker #(
  parameter int DAC_W  = 16,
  parameter int MAX_M  = 16,
  parameter int MEXP_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              applyBit,
  input logic [MEXP_W-1:0] mHeld,
  input logic [DAC_W-1:0]  dacCode,
  input logic [DAC_W-1:0]  result
);
  localparam logic [DAC_W-1:0] HALF = {1'b1, {(DAC_W-1){1'b0}}};

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_result_match: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result == dacCode));

  a_r2_half_scale: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (dacCode == HALF));

  a_r7_trial_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(applyBit)) |-> $stable(dacCode));

  a_r8_m_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mHeld >= MEXP_W'(1) && mHeld <= MEXP_W'(MAX_M)));
endmodule

bind sarTransitionFinder sarFinderChecker #(.DAC_W(DAC_W), .MAX_M(MAX_M), .MEXP_W(MEXP_W)) chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .applyBit(strobe.applyBit), .mHeld(mHeld), .dacCode(dacCode), .result(result)
);

// File: tb/sarTransitionFinder_test.sv
module sarTransitionFinder_test;
  localparam int DAC_W = 12;
  localparam int ADC_W = 8;
  localparam int SHIFT = DAC_W - ADC_W;
  localparam int SETTLE = 3;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADC_W-1:0] targetCode = '0;
  logic [4:0] winExp = 5'd1;
  logic [ADC_W-1:0] adcCode;
  logic [DAC_W-1:0] dacCode, result;
  logic done;

  int nCmp = 0;
  int nBad = 0;
  int duty = 0;          // 0 clean, 1 half, 2 three-quarter, 3 quarter
  logic [1:0] nz = '0;
  logic noiseHi;
  int modelT = 0;

  always #5 clk = ~clk;

  sarTransitionFinder #(.DAC_W(DAC_W), .ADC_W(ADC_W), .MAX_M(16), .SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .targetCode(targetCode), .winExp(winExp),
    .adcCode(adcCode), .dacCode(dacCode), .result(result), .done(done)
  );

  always_ff @(posedge clk) nz <= nz + 2'd1;

  always_comb begin
    case (duty)
      1: noiseHi = nz[0];
      2: noiseHi = (nz != 2'd0);
      3: noiseHi = (nz == 2'd0);
      default: noiseHi = 1'b0;
    endcase
    if (int'(dacCode >> SHIFT) == modelT && noiseHi)
      adcCode = ADC_W'(modelT + 1);
    else
      adcCode = ADC_W'(dacCode >> SHIFT);
  end

  // {target, M, duty}
  localparam logic [23:0] VEC [10] = '{
    {8'd100, 8'd1, 8'd0}, {8'd100, 8'd2, 8'd2}, {8'd37, 8'd3, 8'd1},
    {8'd200, 8'd4, 8'd2}, {8'd255, 8'd2, 8'd0}, {8'd0, 8'd3, 8'd0},
    {8'd0, 8'd2, 8'd2},   {8'd128, 8'd5, 8'd3}, {8'd64, 8'd1, 8'd1},
    {8'd5, 8'd2, 8'd0}
  };

  function automatic int expWord(input int t, input int d);
    int v;
    if (d == 2) v = (t << SHIFT) - 1;
    else        v = ((t + 1) << SHIFT) - 1;
    if (v < 0) v = 0;
    if (v > (1 << DAC_W) - 1) v = (1 << DAC_W) - 1;
    return v;
  endfunction

  function automatic int expLen(input int m);
    return DAC_W * (SETTLE + (1 << m) + 1);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic launch(input int t, input int m);
    @(negedge clk);
    targetCode = ADC_W'(t);
    modelT = t;
    winExp = 5'(m);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(inout int cyc);
    while (!done && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) chk("watchdog conversion timeout", 0, 1);
  endtask

  initial begin
    #(10 * 190000);
    nBad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp + 1, nBad);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 result after reset", int'(result), 0);
    chk("R1 dacCode after reset", int'(dacCode), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VEC[i]) begin
      int t, m;
      t = int'(VEC[i][23:16]);
      m = int'(VEC[i][15:8]);
      duty = int'(VEC[i][7:0]);
      launch(t, m);
      chk("R2 first trial half scale", int'(dacCode), 1 << (DAC_W - 1));
      cyc = 0;
      waitDone(cyc);
      chk("R3 search length", cyc, expLen(m));
      chk("R4 R5 converged word", int'(result), expWord(t, duty));
      chk("R6 dacCode equals result", int'(dacCode), int'(result));
      @(negedge clk);
      chk("R6 done single cycle", int'(done), 0);
      chk("R6 result held", int'(result), expWord(t, duty));
    end

    // start while busy is ignored
    duty = 0;
    launch(50, 3);
    cyc = 0;
    repeat (40) begin @(negedge clk); cyc++; end
    targetCode = 8'd200;
    start = 1'b1;
    @(negedge clk); cyc++;
    start = 1'b0;
    waitDone(cyc);
    chk("R7 length unchanged by busy start", cyc, expLen(3));
    chk("R7 original target kept", int'(result), expWord(50, 0));
    @(negedge clk);
    chk("R7 no restart after done", int'(done), 0);

    // M and target captured at start
    launch(90, 2);
    cyc = 0;
    repeat (10) begin @(negedge clk); cyc++; end
    winExp = 5'd5;
    targetCode = 8'd10;
    waitDone(cyc);
    chk("R8 M held for whole search", cyc, expLen(2));
    chk("R8 target held for whole search", int'(result), expWord(90, 0));

    // M of zero behaves as one
    launch(77, 0);
    cyc = 0;
    waitDone(cyc);
    chk("R8 M zero clamps to one", cyc, expLen(1));
    chk("R8 result with clamped M", int'(result), expWord(77, 0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule